// File: doc/BRIEF.md
# Banked MSI Capture and Interrupt Aggregator

This block receives inbound message-signalled interrupt writes and merges them with four level-style legacy interrupt lines into a single interrupt line for a CPU. Software gives each of eight banks its own 64-bit capture address. An inbound write that hits an enabled bank's address sets one status bit in that bank. The write data, 0 to 31, picks which bit. Per-vector enables decide which pending bits count toward a bank summary.

The bank summaries and the legacy line states are gathered into one top-level status word with fixed bit positions. A top-level enable word masks that status, and the OR of the unmasked bits drives the registered CPU interrupt. An interrupt handler reads the top status, services a bank by clearing its status bits with write-1-to-clear, and then clears the bank summary. A legacy bit can only be cleared once its line has dropped.

Software uses a simple register port: a write strobe, a read strobe and a byte address. Read data is registered one cycle after the read strobe. Inbound traffic arrives on a separate port with a valid bit, a 64-bit address and 32-bit data, one write per cycle.

Top module: `msi_aggregator`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq_o` is 0.
- R2: Register map, byte addresses, read data valid on the cycle after `reg_rd`. The top status is at 0x00, the top enable at 0x04 and the bank enable at 0x08. Bank i uses the slot at 0x40 + 16·i: capture address bits 31:0 at +0, status at +4, vector enable at +8. Capture address bits 63:32 of bank i are at 0xC0 + 4·i.
- R3: An inbound write with data N < 32, whose 64-bit address equals the capture address of a bank that has its bank-enable bit set (bit i of 0x08), sets status bit N of that bank.
- R4: An inbound write is dropped with no effect on any status when its data is 32 or more, when its address matches no bank, or when the matching bank's enable bit is 0.
- R5: Writing the bank status register clears each bit written as 1 and keeps each bit written as 0. If a capture and a clear hit the same bit in the same cycle, the capture wins.
- R6: Top status bit 8+i (bank summary) is set when any bit of bank i's status AND vector enable is 1. It stays set after those bits clear, until written with 1 at 0x00. If bits are still pending after that write, it is set again.
- R7: Top status bit 24+k (legacy line k) is set while `intx_i[k]` is high. Writing 1 to it clears it only when the line is low.
- R8: The top enable register keeps only bits 8 to 15 and 24 to 27, and the other bits read 0. `irq_o` is 1, one cycle later, exactly when some top status bit and its enable bit are both 1.
- R9: The vector enable does not gate capture. A disabled vector still sets its status bit but does not raise the bank summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| inb_valid | input | 1 | Inbound write valid |
| inb_addr | input | 64 | Inbound write address |
| inb_data | input | 32 | Inbound write data (vector number) |
| intx_i | input | 4 | Legacy interrupt lines A to D, active high |
| irq_o | output | 1 | Combined CPU interrupt |

## Verification
Some properties are checked on every cycle:
- A hit on an enabled bank sets the addressed status bit on the next edge.
- An out-of-range vector leaves every status word unchanged.
- A pending enabled vector raises its bank summary.
- An asserted legacy line shows in its status bit.
- A rising interrupt is always backed by an enabled status bit.

The bench scenarios cover the rest:
- The sticky summary that re-arms after a clear while bits are still pending.
- A capture winning over a clear of the same bit in the same cycle.
- A legacy bit refusing its clear while the line is high.
- The masking of the top enable register.
- A long random mix of hits, misses, disabled banks and clears, compared against a model.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int REG_DW      = 32;
  // fixed register offsets (bytes)
  localparam int OFS_TOP_STAT  = 'h00;
  localparam int OFS_TOP_EN    = 'h04;
  localparam int OFS_BANK_EN   = 'h08;
  localparam int OFS_SLOT_BASE = 'h40;
  localparam int SLOT_STRIDE   = 'h10;
  localparam int SLOT_CAP_LO   = 'h0;
  localparam int SLOT_STAT     = 'h4;
  localparam int SLOT_VEN      = 'h8;
  localparam int OFS_HI_BASE   = 'hC0;
  localparam int HI_STRIDE     = 'h4;
  // fixed bit positions inside the top status / enable words
  localparam int SUM_LSB = 8;
  localparam int LEG_LSB = 24;
endpackage

// File: rtl/msi_bank.sv
module msi_bank #(
  parameter int VEC_PER_BANK = 32,
  parameter int INB_AW       = 64,
  localparam int VIDX_W      = $clog2(VEC_PER_BANK),
  localparam int HI_W        = INB_AW - 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bank_on,
  input  logic                    inb_valid,
  input  logic [INB_AW-1:0]       inb_addr,
  input  logic [31:0]             inb_data,
  input  logic [31:0]             wdata,
  input  logic                    we_lo,
  input  logic                    we_hi,
  input  logic                    we_stat,
  input  logic                    we_ven,
  input  logic                    sum_clr,
  output logic [INB_AW-1:0]       cap_addr,
  output logic [VEC_PER_BANK-1:0] status,
  output logic [VEC_PER_BANK-1:0] ven,
  output logic                    summary
);
  logic [31:0]             cap_lo_q;
  logic [HI_W-1:0]         cap_hi_q;
  logic [VEC_PER_BANK-1:0] stat_q, ven_q, set_vec, clr_vec;
  logic                    sum_q, hit, in_range;

  assign cap_addr = {cap_hi_q, cap_lo_q};
  assign in_range = (inb_data < 32'(VEC_PER_BANK));
  assign hit      = inb_valid && bank_on && in_range && (inb_addr == cap_addr);

  always_comb begin
    set_vec = '0;
    if (hit) set_vec = VEC_PER_BANK'(1) << inb_data[VIDX_W-1:0];
    clr_vec = we_stat ? wdata[VEC_PER_BANK-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lo_q <= '0;
      cap_hi_q <= '0;
      ven_q    <= '0;
      stat_q   <= '0;
      sum_q    <= 1'b0;
    end else begin
      if (we_lo)  cap_lo_q <= wdata;
      if (we_hi)  cap_hi_q <= wdata[HI_W-1:0];
      if (we_ven) ven_q    <= wdata[VEC_PER_BANK-1:0];
      stat_q <= (stat_q & ~clr_vec) | set_vec;
      sum_q  <= (sum_q & ~sum_clr) | (|(stat_q & ven_q));
    end
  end

  assign status  = stat_q;
  assign ven     = ven_q;
  assign summary = sum_q;
endmodule

// File: rtl/msi_legacy_stat.sv
module msi_legacy_stat #(
  parameter int NUM_LEG = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LEG-1:0] line_i,
  input  logic [NUM_LEG-1:0] clr_i,
  output logic [NUM_LEG-1:0] stat_o
);
  logic [NUM_LEG-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= line_i | (stat_q & ~clr_i);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/msi_aggregator.sv
module msi_aggregator
  import msi_agg_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int VEC_PER_BANK = 32,
  parameter int NUM_LEG      = 4,
  parameter int REG_AW       = 8,
  parameter int INB_AW       = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              inb_valid,
  input  logic [INB_AW-1:0] inb_addr,
  input  logic [31:0]       inb_data,
  input  logic [NUM_LEG-1:0] intx_i,
  output logic              irq_o
);
  localparam logic [31:0] SUM_MASK = 32'(((64'd1 << NUM_BANKS) - 1) << SUM_LSB);
  localparam logic [31:0] LEG_MASK = 32'(((64'd1 << NUM_LEG) - 1) << LEG_LSB);
  localparam logic [31:0] TOP_MASK = SUM_MASK | LEG_MASK;

  logic [NUM_BANKS-1:0][INB_AW-1:0]       cap_addr_all;
  logic [NUM_BANKS-1:0][VEC_PER_BANK-1:0] status_all;
  logic [NUM_BANKS-1:0][VEC_PER_BANK-1:0] ven_all;
  logic [NUM_BANKS-1:0]                   sum_all;
  logic [NUM_LEG-1:0]                     leg_stat, leg_clr;
  logic [NUM_BANKS-1:0]                   bank_en_q;
  logic [31:0]                            top_en_q, top_stat, rd_mux, rdata_q;
  logic                                   irq_q, top_stat_wr;

  assign top_stat_wr = reg_wr && (reg_addr == REG_AW'(OFS_TOP_STAT));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    localparam logic [REG_AW-1:0] A_LO   = REG_AW'(OFS_SLOT_BASE + i*SLOT_STRIDE + SLOT_CAP_LO);
    localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_SLOT_BASE + i*SLOT_STRIDE + SLOT_STAT);
    localparam logic [REG_AW-1:0] A_VEN  = REG_AW'(OFS_SLOT_BASE + i*SLOT_STRIDE + SLOT_VEN);
    localparam logic [REG_AW-1:0] A_HI   = REG_AW'(OFS_HI_BASE + i*HI_STRIDE);

    msi_bank #(
      .VEC_PER_BANK (VEC_PER_BANK),
      .INB_AW       (INB_AW)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .bank_on   (bank_en_q[i]),
      .inb_valid (inb_valid),
      .inb_addr  (inb_addr),
      .inb_data  (inb_data),
      .wdata     (reg_wdata),
      .we_lo     (reg_wr && reg_addr == A_LO),
      .we_hi     (reg_wr && reg_addr == A_HI),
      .we_stat   (reg_wr && reg_addr == A_STAT),
      .we_ven    (reg_wr && reg_addr == A_VEN),
      .sum_clr   (top_stat_wr && reg_wdata[SUM_LSB+i]),
      .cap_addr  (cap_addr_all[i]),
      .status    (status_all[i]),
      .ven       (ven_all[i]),
      .summary   (sum_all[i])
    );
  end

  assign leg_clr = top_stat_wr ? reg_wdata[LEG_LSB +: NUM_LEG] : '0;

  msi_legacy_stat #(.NUM_LEG(NUM_LEG)) u_legacy (
    .clk    (clk),
    .rst    (rst),
    .line_i (intx_i),
    .clr_i  (leg_clr),
    .stat_o (leg_stat)
  );

  always_comb begin
    top_stat = '0;
    top_stat[SUM_LSB +: NUM_BANKS] = sum_all;
    top_stat[LEG_LSB +: NUM_LEG]   = leg_stat;
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == REG_AW'(OFS_TOP_STAT)) rd_mux = top_stat;
    if (reg_addr == REG_AW'(OFS_TOP_EN))   rd_mux = top_en_q;
    if (reg_addr == REG_AW'(OFS_BANK_EN))  rd_mux = 32'(bank_en_q);
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (reg_addr == REG_AW'(OFS_SLOT_BASE + i*SLOT_STRIDE + SLOT_CAP_LO))
        rd_mux = cap_addr_all[i][31:0];
      if (reg_addr == REG_AW'(OFS_SLOT_BASE + i*SLOT_STRIDE + SLOT_STAT))
        rd_mux = 32'(status_all[i]);
      if (reg_addr == REG_AW'(OFS_SLOT_BASE + i*SLOT_STRIDE + SLOT_VEN))
        rd_mux = 32'(ven_all[i]);
      if (reg_addr == REG_AW'(OFS_HI_BASE + i*HI_STRIDE))
        rd_mux = 32'(cap_addr_all[i][INB_AW-1:32]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_en_q  <= '0;
      bank_en_q <= '0;
      rdata_q   <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == REG_AW'(OFS_TOP_EN))  top_en_q  <= reg_wdata & TOP_MASK;
      if (reg_wr && reg_addr == REG_AW'(OFS_BANK_EN)) bank_en_q <= reg_wdata[NUM_BANKS-1:0];
      if (reg_rd) rdata_q <= rd_mux;
      irq_q <= |(top_stat & top_en_q);
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/msi_aggregator_chk.sv
module msi_aggregator_chk
  import msi_agg_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int VEC_PER_BANK = 32,
  parameter int NUM_LEG      = 4,
  parameter int INB_AW       = 64,
  localparam int VIDX_W      = $clog2(VEC_PER_BANK)
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   reg_wr,
  input logic                                   inb_valid,
  input logic [INB_AW-1:0]                      inb_addr,
  input logic [31:0]                            inb_data,
  input logic [NUM_BANKS-1:0]                   bank_en,
  input logic [NUM_BANKS-1:0][INB_AW-1:0]       cap_addr_all,
  input logic [NUM_BANKS-1:0][VEC_PER_BANK-1:0] status_all,
  input logic [NUM_BANKS-1:0][VEC_PER_BANK-1:0] ven_all,
  input logic [NUM_BANKS-1:0]                   sum_all,
  input logic [NUM_LEG-1:0]                     intx,
  input logic [31:0]                            top_stat,
  input logic [31:0]                            top_en,
  input logic                                   irq
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
    // R3: a hit on an enabled bank sets the addressed vector next cycle
    a_r3_capture_sets: assert property (@(posedge clk) disable iff (rst)
      (inb_valid && bank_en[i] && inb_addr == cap_addr_all[i] &&
       inb_data < 32'(VEC_PER_BANK))
      |=> status_all[i][$past(inb_data[VIDX_W-1:0])]);

    // R6: pending enabled vector raises the bank summary
    a_r6_summary_raise: assert property (@(posedge clk) disable iff (rst)
      (|(status_all[i] & ven_all[i])) |=> sum_all[i]);
  end

  // R4: out-of-range vector changes nothing when software is idle
  a_r4_drop_range: assert property (@(posedge clk) disable iff (rst)
    (inb_valid && inb_data >= 32'(VEC_PER_BANK) && !reg_wr)
    |=> $stable(status_all));

  for (genvar k = 0; k < NUM_LEG; k++) begin : g_leg
    // R7: an asserted legacy line is visible in its status bit
    a_r7_legacy_hold: assert property (@(posedge clk) disable iff (rst)
      intx[k] |=> top_stat[LEG_LSB+k]);
  end

  // R8: interrupt only rises when an enabled status bit was set
  a_r8_irq_backed: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(top_stat & top_en)));
endmodule

bind msi_aggregator msi_aggregator_chk #(
  .NUM_BANKS    (NUM_BANKS),
  .VEC_PER_BANK (VEC_PER_BANK),
  .NUM_LEG      (NUM_LEG),
  .INB_AW       (INB_AW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_wr       (reg_wr),
  .inb_valid    (inb_valid),
  .inb_addr     (inb_addr),
  .inb_data     (inb_data),
  .bank_en      (bank_en_q),
  .cap_addr_all (cap_addr_all),
  .status_all   (status_all),
  .ven_all      (ven_all),
  .sum_all      (sum_all),
  .intx         (intx_i),
  .top_stat     (top_stat),
  .top_en       (top_en_q),
  .irq          (irq_o)
);

// File: tb/tb_msi_aggregator.sv
module tb_msi_aggregator;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        inb_valid = 1'b0;
  logic [63:0] inb_addr = '0;
  logic [31:0] inb_data = '0;
  logic [3:0]  intx_i = '0;
  logic        irq_o;

  always #4 clk = ~clk;

  msi_aggregator dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .inb_valid(inb_valid), .inb_addr(inb_addr), .inb_data(inb_data),
    .intx_i(intx_i), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [63:0] m_cap [NB];
  logic [31:0] m_stat [NB];
  logic [31:0] m_ven [NB];
  logic [7:0]  m_sum = '0, m_ben = '0;
  logic [3:0]  m_leg = '0;
  logic [31:0] m_ten = '0;

  function automatic logic [7:0] a_stat(int b); return 8'('h40 + b*16 + 4); endfunction
  function automatic logic [7:0] a_ven(int b);  return 8'('h40 + b*16 + 8); endfunction
  function automatic logic [7:0] a_lo(int b);   return 8'('h40 + b*16); endfunction
  function automatic logic [7:0] a_hi(int b);   return 8'('hC0 + b*4); endfunction

  function automatic logic [31:0] m_top();
    logic [31:0] t = '0;
    t[15:8]  = m_sum;
    t[27:24] = m_leg;
    return t;
  endfunction

  function automatic void m_refresh();
    for (int i = 0; i < NB; i++)
      if (|(m_stat[i] & m_ven[i])) m_sum[i] = 1'b1;
    m_leg = m_leg | intx_i;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic inbound(logic [63:0] a, logic [31:0] d);
    @(negedge clk); inb_valid = 1'b1; inb_addr = a; inb_data = d;
    @(negedge clk); inb_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // model updates
  task automatic do_inbound(logic [63:0] a, logic [31:0] d);
    inbound(a, d);
    for (int i = 0; i < NB; i++)
      if (m_ben[i] && a == m_cap[i] && d < 32) m_stat[i][d[4:0]] = 1'b1;
    m_refresh();
  endtask

  task automatic do_stat_clr(int b, logic [31:0] m);
    reg_write(a_stat(b), m);
    m_stat[b] &= ~m;
    m_refresh();
  endtask

  task automatic do_ven(int b, logic [31:0] v);
    reg_write(a_ven(b), v);
    m_ven[b] = v;
    m_refresh();
  endtask

  task automatic do_top_clr(logic [31:0] m);
    reg_write(8'h00, m);
    m_sum &= ~m[15:8];
    m_leg &= ~m[27:24] | intx_i;
    m_refresh();
  endtask

  task automatic check_bank(int b, string req);
    logic [31:0] v;
    reg_read(a_stat(b), v); check({req, " bank status"}, v, m_stat[b]);
    reg_read(8'h00, v);     check({req, " top status"}, v, m_top());
    check({req, " irq"}, 32'(irq_o), 32'(|(m_top() & m_ten)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240109));
    for (int i = 0; i < NB; i++) begin
      m_cap[i] = {32'hA0 + 32'(i), 32'h0004_0000 + 32'(i) * 32'h1000};
      m_stat[i] = '0; m_ven[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    reg_read(8'h00, v); check("R1 top status", v, 0);
    reg_read(8'h04, v); check("R1 top enable", v, 0);
    reg_read(8'h08, v); check("R1 bank enable", v, 0);
    reg_read(a_stat(7), v); check("R1 bank7 status", v, 0);

    // R2 program capture addresses and read back
    for (int i = 0; i < NB; i++) begin
      reg_write(a_lo(i), m_cap[i][31:0]);
      reg_write(a_hi(i), m_cap[i][63:32]);
    end
    reg_read(a_lo(3), v); check("R2 cap lo bank3", v, m_cap[3][31:0]);
    reg_read(a_hi(6), v); check("R2 cap hi bank6", v, m_cap[6][63:32]);
    reg_write(8'h08, 32'hFF); m_ben = 8'hFF;
    reg_read(8'h08, v); check("R2 bank enable", v, 32'hFF);

    // R8 top enable mask
    reg_write(8'h04, 32'hFFFF_FFFF); m_ten = 32'h0F00_FF00;
    reg_read(8'h04, v); check("R8 top enable mask", v, 32'h0F00_FF00);

    // R3 + R9: capture into a bank with vector disabled
    do_inbound(m_cap[2], 5);
    check_bank(2, "R3 R9 capture no summary");
    // R6 enabling the vector raises the summary and irq
    do_ven(2, 32'h20);
    check_bank(2, "R6 summary after enable");

    // R4 drop cases
    do_inbound(m_cap[3], 32);
    check_bank(3, "R4 data out of range");
    do_inbound(m_cap[3] ^ 64'h10, 1);
    check_bank(3, "R4 address miss");
    reg_write(8'h08, 32'hEF); m_ben = 8'hEF;
    do_inbound(m_cap[4], 2);
    check_bank(4, "R4 bank disabled");
    reg_write(8'h08, 32'hFF); m_ben = 8'hFF;

    // R5 write-0 keeps, write-1 clears
    do_stat_clr(2, 32'h0);
    check_bank(2, "R5 write zero keeps");
    do_stat_clr(2, 32'h20);
    check_bank(2, "R5 write one clears");
    // R6 summary sticky, then cleared
    do_top_clr(32'h0000_0400);
    check_bank(2, "R6 summary cleared");

    // R6 re-arm when bits still pending
    do_ven(1, 32'hFFFF_FFFF);
    do_inbound(m_cap[1], 7);
    do_top_clr(32'h0000_0200);
    check_bank(1, "R6 summary re-arms");

    // R5 capture wins over same-cycle clear
    @(negedge clk);
    inb_valid = 1'b1; inb_addr = m_cap[1]; inb_data = 9;
    reg_wr = 1'b1; reg_addr = a_stat(1); reg_wdata = 32'h200;
    @(negedge clk);
    inb_valid = 1'b0; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    m_stat[1][9] = 1'b1; m_refresh();
    check_bank(1, "R5 capture wins");

    // R7 legacy lines
    do_stat_clr(1, 32'hFFFF_FFFF);
    do_top_clr(32'h0000_FF00);
    reg_write(8'h04, 32'h0F00_0000); m_ten = 32'h0F00_0000;
    @(negedge clk); intx_i = 4'b0101;
    repeat (3) @(negedge clk); m_refresh();
    check_bank(0, "R7 legacy set");
    do_top_clr(32'h0F00_0000);
    check_bank(0, "R7 clear ignored while high");
    @(negedge clk); intx_i = 4'b0000;
    repeat (3) @(negedge clk); m_refresh();
    check_bank(0, "R7 sticky after drop");
    do_top_clr(32'h0500_0000);
    check_bank(0, "R7 cleared after drop");
    reg_write(8'h04, 32'hFFFF_FFFF); m_ten = 32'h0F00_FF00;

    // random mix: R3 R4 R5 R6 R8 R9
    for (int it = 0; it < 300; it++) begin
      int b = int'($urandom % NB);
      int kind = int'($urandom % 8);
      case (kind)
        0, 1, 2: do_inbound(m_cap[b], $urandom % 40);
        3:       do_inbound(m_cap[b] ^ 64'h1000_0000_0000, $urandom % 32);
        4:       do_stat_clr(b, $urandom);
        5:       do_ven(b, $urandom & $urandom);
        6:       do_top_clr($urandom);
        default: begin
          logic [7:0] be = 8'($urandom) | 8'h81;
          reg_write(8'h08, 32'(be)); m_ben = be;
        end
      endcase
      check_bank(b, "R3 R4 R5 R6 R8 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule